// File: doc/BRIEF.md
# Four-Bit Mini ALU

This block is a purely combinational arithmetic and logic unit for small operands. One operand bus carries both inputs: the low half is operand A and the high half is operand B. A three-bit operation code chooses one of eight functions: two arithmetic, three bitwise, one inversion and two pass-throughs. The block returns a result of the operand width and a single status flag.

For addition, the flag is the carry out of the sum. For subtraction, it is the inverted borrow, so it reads 1 whenever A is not below B as unsigned numbers. Every other operation clears the flag. The block also presents the result and flag as one wider output word, with zeros above the flag, so that a surrounding multiplexer can forward it unchanged.

With the default parameters, the operands are 4 bits and the packed word is 8 bits. The result appears in the same cycle the inputs change, with no latency.

Top module: `mini_alu`

## Requirements
- R1: Opcode 000 gives Y = (A + B) mod 16, and the flag equals the carry out of the 4-bit sum.
- R2: Opcode 001 gives Y = (A - B) mod 16, and the flag is 1 exactly when A >= B as unsigned numbers (inverted borrow).
- R3: Opcodes 010, 011 and 100 give Y = A AND B, A OR B and A XOR B, bit by bit.
- R4: Opcode 101 gives Y = bitwise inverse of A.
- R5: Opcode 110 gives Y = A, and opcode 111 gives Y = B.
- R6: For every opcode from 010 to 111, the flag is 0.
- R7: The packed word is {3'b000, flag, Y[3:0]}: bits 3..0 hold Y, bit 4 holds the flag, and bits 7..5 are 0.
- R8: A is taken from operand bus bits 3..0 and B from bits 7..4.
- R9: The block holds no state, so its outputs depend only on the present operand and opcode values, with no reset dependence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 8 | Operand bus; A in bits 3..0, B in bits 7..4 |
| opcode_i | input | 3 | Operation select |
| result_o | output | 4 | Result Y |
| flag_o | output | 1 | Carry (add), inverted borrow (subtract), else 0 |
| word_o | output | 8 | Packed {000, flag, Y} |

## Verification
The embedded checks assume the opcode and operand bus never carry unknown values. Under that assumption, every opcode maps onto one of the eight defined cases, and each width-extended comparison stays well defined. The stimulus drives only the 256 defined operand values. It pairs each of them with all eight opcodes and updates the inputs away from the sampling edge, so every check sees settled, fully known values.

// File: rtl/mini_alu_pkg.sv
package mini_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD   = 3'b000,
        OP_SUB   = 3'b001,
        OP_AND   = 3'b010,
        OP_OR    = 3'b011,
        OP_XOR   = 3'b100,
        OP_NOTA  = 3'b101,
        OP_PASSA = 3'b110,
        OP_PASSB = 3'b111
    } alu_op_e;

    function automatic logic op_is_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o
);

    typedef struct packed {
        logic [W-1:0] b_eff;
        logic [W:0]   full;
    } arith_t;

    arith_t calc_d;

    // Single adder shared by both operations: subtract is A + ~B + 1.
    always_comb begin
        calc_d       = '0;
        calc_d.b_eff = sub_i ? ~b_i : b_i;
        calc_d.full  = {1'b0, a_i} + {1'b0, calc_d.b_eff} + (W+1)'(sub_i);
    end

    assign sum_o   = calc_d.full[W-1:0];
    assign carry_o = calc_d.full[W];

    always_comb begin
        if (!sub_i) begin
            assert_add_carry_R1: assert ({carry_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i}))
                else $error("add sum/carry mismatch");
        end else begin
            assert_sub_notborrow_R2: assert (carry_o == (a_i >= b_i))
                else $error("subtract flag mismatch");
            assert_sub_wrap_R2: assert (W'(sum_o + b_i) == a_i)
                else $error("subtract result mismatch");
        end
    end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import mini_alu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  alu_op_e      op_i,
    output logic [W-1:0] res_o
);

    logic [W-1:0] res_d;

    always_comb begin
        unique case (op_i)
            OP_AND:   res_d = a_i & b_i;
            OP_OR:    res_d = a_i | b_i;
            OP_XOR:   res_d = a_i ^ b_i;
            OP_NOTA:  res_d = ~a_i;
            OP_PASSA: res_d = a_i;
            OP_PASSB: res_d = b_i;
            default:  res_d = '0;
        endcase
    end

    assign res_o = res_d;

    always_comb begin
        if (op_i == OP_NOTA) begin
            assert_invert_R4: assert ((res_o ^ a_i) == {W{1'b1}})
                else $error("inverse mismatch");
        end
        if (op_i == OP_PASSA) begin
            assert_pass_a_R5: assert (res_o == a_i) else $error("pass A mismatch");
        end
        if (op_i == OP_PASSB) begin
            assert_pass_b_R5: assert (res_o == b_i) else $error("pass B mismatch");
        end
    end

endmodule

// File: rtl/mini_alu.sv
module mini_alu
    import mini_alu_pkg::*;
#(
    parameter int W      = 4,
    parameter int WORD_W = 8
) (
    input  logic [2*W-1:0]    opnd_i,
    input  logic [2:0]        opcode_i,
    output logic [W-1:0]      result_o,
    output logic              flag_o,
    output logic [WORD_W-1:0] word_o
);

    localparam int PAD_W = WORD_W - W - 1;

    typedef struct packed {
        logic         flag;
        logic [W-1:0] y;
    } alu_out_t;

    alu_op_e      op_d;
    logic [W-1:0] a_d, b_d;
    logic [W-1:0] arith_y, logic_y;
    logic         arith_c;
    alu_out_t     out_d;

    assign op_d = alu_op_e'(opcode_i);
    assign a_d  = opnd_i[W-1:0];
    assign b_d  = opnd_i[2*W-1:W];

    alu_arith #(.W(W)) u_arith (
        .a_i     (a_d),
        .b_i     (b_d),
        .sub_i   (op_d == OP_SUB),
        .sum_o   (arith_y),
        .carry_o (arith_c)
    );

    alu_logic #(.W(W)) u_logic (
        .a_i   (a_d),
        .b_i   (b_d),
        .op_i  (op_d),
        .res_o (logic_y)
    );

    always_comb begin
        out_d = '0;
        if (op_is_arith(op_d)) begin
            out_d.y    = arith_y;
            out_d.flag = arith_c;
        end else begin
            out_d.y    = logic_y;
            out_d.flag = 1'b0;
        end
    end

    assign result_o = out_d.y;
    assign flag_o   = out_d.flag;

    generate
        if (PAD_W > 0) begin : g_pad
            assign word_o = {{PAD_W{1'b0}}, out_d.flag, out_d.y};
        end else begin : g_nopad
            assign word_o = {out_d.flag, out_d.y};
        end
    endgenerate

    always_comb begin
        if (!op_is_arith(op_d)) begin
            assert_logic_flag_clear_R6: assert (flag_o == 1'b0)
                else $error("flag set on non-arithmetic op");
        end
        assert_word_low_R7: assert (word_o[W-1:0] == result_o && word_o[W] == flag_o)
            else $error("packed word mismatch");
        assert_word_pad_R7: assert ((word_o >> (W+1)) == '0)
            else $error("packed word padding nonzero");
    end

endmodule

// File: tb/mini_alu_test.sv
`timescale 1ns/1ps
module mini_alu_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] opnd;
    logic [2:0] opcode;
    logic [3:0] result;
    logic       flag;
    logic [7:0] word;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    mini_alu uut (
        .opnd_i   (opnd),
        .opcode_i (opcode),
        .result_o (result),
        .flag_o   (flag),
        .word_o   (word)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic drive(input int a, input int b, input int op);
        @(posedge clk);
        #2;
        opnd   = 8'((b << 4) | a);
        opcode = 3'(op);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        opnd   = 8'h00;
        opcode = 3'b000;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: no state; zero inputs give zero sum, no carry
        chk("R9", "result after reset", int'(result), 0);
        chk("R9", "flag after reset", int'(flag), 0);
        chk("R7", "word after reset", int'(word), 0);

        // R8: operand placement with asymmetric operands
        drive(3, 12, 6);
        chk("R8", "pass A from low nibble", int'(result), 3);
        drive(3, 12, 7);
        chk("R8", "pass B from high nibble", int'(result), 12);
        drive(9, 2, 1);
        chk("R8", "A-B order", int'(result), 7);

        for (int op = 0; op < 8; op++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    int    ey;
                    int    ef;
                    string tg;
                    drive(a, b, op);
                    case (op)
                        0: begin ey = (a + b) % 16; ef = (a + b) / 16; tg = "R1"; end
                        1: begin ey = (a - b + 16) % 16; ef = (a >= b) ? 1 : 0; tg = "R2"; end
                        2: begin ey = a & b; ef = 0; tg = "R3"; end
                        3: begin ey = a | b; ef = 0; tg = "R3"; end
                        4: begin ey = a ^ b; ef = 0; tg = "R3"; end
                        5: begin ey = 15 - a; ef = 0; tg = "R4"; end
                        6: begin ey = a; ef = 0; tg = "R5"; end
                        default: begin ey = b; ef = 0; tg = "R5"; end
                    endcase
                    chk(tg, $sformatf("Y op=%0d a=%0d b=%0d", op, a, b), int'(result), ey);
                    chk((op < 2) ? tg : "R6", $sformatf("flag op=%0d a=%0d b=%0d", op, a, b),
                        int'(flag), ef);
                    chk("R7", $sformatf("word op=%0d a=%0d b=%0d", op, a, b),
                        int'(word), ef * 16 + ey);
                end
            end
        end

        // R2 boundaries: equal operands and zero minus max
        drive(5, 5, 1);
        chk("R2", "equal operands flag", int'(flag), 1);
        drive(0, 15, 1);
        chk("R2", "0-15 result", int'(result), 1);
        chk("R2", "0-15 flag", int'(flag), 0);
        // R1 boundary: max plus max
        drive(15, 15, 0);
        chk("R1", "15+15 word", int'(word), 8'h1E);

        finish_run();
    end

endmodule